// File: doc/BRIEF.md
# Bus Bit Timing and Synchronization Unit

This unit sits between the receive comparator of a serial field-bus node and its protocol engine. It cuts every nominal bit into time quanta, and a programmable clock divider sets the length of one quantum. Each bit is laid out as a one-quantum sync slot, then a first phase segment of 1 to 16 quanta, then a second phase segment of 1 to 8 quanta. The sample point sits at the end of the first phase segment, so the two segment lengths set where in the bit the bus is read.

The unit watches the receive line for recessive-to-dominant transitions. While the protocol engine reports the bus idle, such an edge restarts the bit grid outright, so the quantum of the edge becomes the sync slot. During a frame the grid is nudged instead. An edge that arrives late stretches the first phase segment, and an edge that arrives early trims the second. Either correction is limited by a programmable jump width. The bus value at the sample point is taken either from a single quantum or as a two-of-three vote over the last three quanta. The result goes out as a registered bit together with a one-clock strobe.

Top module: `bittime_core`

## Requirements
- R1: While `rst` is high and on the first clock after it falls, `sample_pulse` is 0 and `sampled_bit` is 1 (recessive).
- R2: One quantum lasts `cfg_prescale`+1 clocks. With no falling edge on `rx`, a bit lasts 1+T1+T2 quanta, where T1 = `cfg_seg1`+1 and T2 = `cfg_seg2`+1. Consecutive strobes are therefore (1+T1+T2)·(`cfg_prescale`+1) clocks apart.
- R3: `sample_pulse` is high for exactly one clock, on the clock that ends the last quantum of the first phase segment.
- R4: The bus level is examined once per quantum, two clocks after it appears on `rx`. A 1-to-0 change seen while `frame_idle` is 1 makes that quantum the sync slot. The first strobe then follows T1 quanta later.
- R5: A falling edge seen in quantum k (1-based) of the first phase segment, while a frame is running, lengthens that segment by min(k, SJW), where SJW = `cfg_sjw`+1.
- R6: A falling edge seen in the second phase segment, with e quanta left in the bit counting its own quantum, starts a new bit at once if e ≤ SJW. Otherwise it shortens the second segment by SJW.
- R7: Only the first qualifying edge in a bit adjusts the grid. An edge that falls inside the sync slot is ignored.
- R8: While `tx_dominant` is 1, edges during a frame do not adjust the grid.
- R9: With `cfg_triple` = 0, `sampled_bit` takes the bus level of the sample quantum, and it changes only on strobe clocks.
- R10: With `cfg_triple` = 1, `sampled_bit` takes the majority of the levels of the last three quanta, ending with the sample quantum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_prescale | input | PRE_W | Quantum length minus one, in clocks |
| cfg_seg1 | input | SEG1_W | First phase segment length minus one, in quanta |
| cfg_seg2 | input | SEG2_W | Second phase segment length minus one, in quanta |
| cfg_sjw | input | SJW_W | Jump width minus one, in quanta |
| cfg_triple | input | 1 | 1 selects the three-quantum majority vote |
| frame_idle | input | 1 | 1 while no frame is in progress (hard sync enabled) |
| tx_dominant | input | 1 | 1 while this node drives a dominant level |
| rx | input | 1 | Bus receive level, 1 recessive, 0 dominant |
| sample_pulse | output | 1 | One-clock strobe at each sample point |
| sampled_bit | output | 1 | Bus value taken at the last sample point |

## Verification
A quiet line with no edges gives the plain bit length and separates a wrong prescaler from wrong segment arithmetic. A single edge while idle measures the delay from hard sync to the first strobe. Square waves run slightly slower than the bit rate push edges into the first phase segment, and waves run slightly faster push them into the second, so late correction can be told apart from early correction. Dense glitch trains check the one-adjustment-per-bit rule and the majority vote, and the same waves with `tx_dominant` raised must leave the grid free-running. A cycle-level bench model is also compared against the unit over random settings, random edge spacing and a hard sync inside each run.

// File: rtl/bittime_pkg.sv
package bittime_pkg;
  localparam int unsigned PRE_W_DEF  = 8;
  localparam int unsigned SEG1_W_DEF = 4;
  localparam int unsigned SEG2_W_DEF = 3;
  localparam int unsigned SJW_W_DEF  = 2;

  function automatic logic vote3(input logic [2:0] v);
    return (v[2] & v[1]) | (v[2] & v[0]) | (v[1] & v[0]);
  endfunction
endpackage

// File: rtl/bittime_prescale.sv
module bittime_prescale #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PRE_W-1:0] div_m1,
  output logic             tick
);
  logic [PRE_W-1:0] cnt;

  assign tick = (cnt == div_m1);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bittime_rxsamp.sv
module bittime_rxsamp
  import bittime_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic rx,
  output logic fall,
  output logic lvl,
  output logic maj
);
  logic       rx_s;
  logic       prev;
  logic [1:0] hist;

  assign lvl  = rx_s;
  assign fall = prev & ~rx_s;
  assign maj  = vote3({hist, rx_s});

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_s <= 1'b1;
      prev <= 1'b1;
      hist <= 2'b11;
    end else begin
      rx_s <= rx;
      if (tick) begin
        prev <= rx_s;
        hist <= {hist[0], rx_s};
      end
    end
  end
endmodule

// File: rtl/bittime_seq.sv
module bittime_seq #(
  parameter int unsigned SEG1_W = 4,
  parameter int unsigned SEG2_W = 3,
  parameter int unsigned SJW_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              fall,
  input  logic              idle,
  input  logic              tx_dom,
  input  logic [SEG1_W-1:0] seg1,
  input  logic [SEG2_W-1:0] seg2,
  input  logic [SJW_W-1:0]  sjw_m1,
  output logic              smp
);
  localparam int unsigned POS_MAX = 1 + (1 << SEG1_W) + (1 << SJW_W) + (1 << SEG2_W);
  localparam int unsigned POS_W   = $clog2(POS_MAX + 1);

  logic [POS_W-1:0] pos, ext, shr;
  logic [POS_W-1:0] pos_n, ext_n, shr_n;
  logic [POS_W-1:0] t1, t2, sjw, end1, endb, end1_n, endb_n, left;
  logic             done, done_n, restart;

  always_comb begin
    t1   = POS_W'(seg1) + POS_W'(1);
    t2   = POS_W'(seg2) + POS_W'(1);
    sjw  = POS_W'(sjw_m1) + POS_W'(1);
    end1 = t1 + ext;
    endb = end1 + t2 - shr;
    left = endb - pos + POS_W'(1);

    ext_n   = ext;
    shr_n   = shr;
    done_n  = done;
    restart = 1'b0;

    if (fall && idle) begin
      restart = 1'b1;
    end else if (fall && !done && !tx_dom && (pos != '0)) begin
      done_n = 1'b1;
      if (pos <= end1)       ext_n = (pos < sjw) ? pos : sjw;
      else if (left <= sjw)  restart = 1'b1;
      else                   shr_n = sjw;
    end

    end1_n = t1 + ext_n;
    endb_n = end1_n + t2 - shr_n;
    smp    = 1'b0;
    pos_n  = pos + POS_W'(1);

    if (restart) begin
      pos_n  = POS_W'(1);
      ext_n  = '0;
      shr_n  = '0;
      done_n = 1'b1;
    end else begin
      smp = (pos == end1_n);
      if (pos == endb_n) begin
        pos_n  = '0;
        ext_n  = '0;
        shr_n  = '0;
        done_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos  <= '0;
      ext  <= '0;
      shr  <= '0;
      done <= 1'b0;
    end else if (tick) begin
      pos  <= pos_n;
      ext  <= ext_n;
      shr  <= shr_n;
      done <= done_n;
    end
  end
endmodule

// File: rtl/bittime_core.sv
module bittime_core
  import bittime_pkg::*;
#(
  parameter int unsigned PRE_W  = PRE_W_DEF,
  parameter int unsigned SEG1_W = SEG1_W_DEF,
  parameter int unsigned SEG2_W = SEG2_W_DEF,
  parameter int unsigned SJW_W  = SJW_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PRE_W-1:0]  cfg_prescale,
  input  logic [SEG1_W-1:0] cfg_seg1,
  input  logic [SEG2_W-1:0] cfg_seg2,
  input  logic [SJW_W-1:0]  cfg_sjw,
  input  logic              cfg_triple,
  input  logic              frame_idle,
  input  logic              tx_dominant,
  input  logic              rx,
  output logic              sample_pulse,
  output logic              sampled_bit
);
  logic tq_tick, fall, lvl, maj, smp;

  bittime_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .div_m1(cfg_prescale), .tick(tq_tick)
  );

  bittime_rxsamp u_rx (
    .clk(clk), .rst(rst), .tick(tq_tick), .rx(rx),
    .fall(fall), .lvl(lvl), .maj(maj)
  );

  bittime_seq #(.SEG1_W(SEG1_W), .SEG2_W(SEG2_W), .SJW_W(SJW_W)) u_seq (
    .clk(clk), .rst(rst), .tick(tq_tick), .fall(fall), .idle(frame_idle),
    .tx_dom(tx_dominant), .seg1(cfg_seg1), .seg2(cfg_seg2), .sjw_m1(cfg_sjw),
    .smp(smp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_pulse <= 1'b0;
      sampled_bit  <= 1'b1;
    end else begin
      sample_pulse <= tq_tick & smp;
      if (tq_tick && smp) sampled_bit <= cfg_triple ? maj : lvl;
    end
  end
endmodule

// File: rtl/bittime_core_chk.sv
module bittime_core_chk #(
  parameter int unsigned PRE_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tq_tick,
  input logic [PRE_W-1:0] cfg_prescale,
  input logic             sample_pulse,
  input logic             sampled_bit
);
  logic [PRE_W-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst || tq_tick) gap <= '0;
    else                gap <= gap + 1'b1;
  end

  a_r1_reset_values: assert property (@(posedge clk)
    rst |=> (!sample_pulse && sampled_bit));

  a_r2_quantum_length: assert property (@(posedge clk) disable iff (rst)
    tq_tick |-> (gap == cfg_prescale));

  a_r3_single_clock_strobe: assert property (@(posedge clk) disable iff (rst)
    sample_pulse |=> !sample_pulse);

  a_r3_strobe_after_tick: assert property (@(posedge clk) disable iff (rst)
    sample_pulse |-> $past(tq_tick));

  a_r9_bit_moves_on_strobe: assert property (@(posedge clk) disable iff (rst)
    !$stable(sampled_bit) |-> sample_pulse);
endmodule

bind bittime_core bittime_core_chk #(.PRE_W(PRE_W)) u_chk (
  .clk(clk), .rst(rst), .tq_tick(tq_tick), .cfg_prescale(cfg_prescale),
  .sample_pulse(sample_pulse), .sampled_bit(sampled_bit)
);

// File: tb/bittime_core_test.sv
module bittime_core_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] c_pre = 8'd1;
  logic [3:0] c_s1 = 4'd5;
  logic [2:0] c_s2 = 3'd2;
  logic [1:0] c_sj = 2'd1;
  logic       c_tr = 1'b0;
  logic       idle = 1'b1;
  logic       txd = 1'b0;
  logic       rx = 1'b1;
  logic       pulse, sbit;

  int    n_cmp = 0, n_bad = 0, cyc = 0;
  bit    finished = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  bittime_core uut (
    .clk(clk), .rst(rst), .cfg_prescale(c_pre), .cfg_seg1(c_s1),
    .cfg_seg2(c_s2), .cfg_sjw(c_sj), .cfg_triple(c_tr), .frame_idle(idle),
    .tx_dominant(txd), .rx(rx), .sample_pulse(pulse), .sampled_bit(sbit)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, int act, int exp, string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // Reference model, stepped per clock from the requirements
  int m_cnt, seg, k, len1, len2, T1, T2, SJ;
  bit m_rxs, m_prev, done, e_pulse, e_bit, L, tk, ed, rs, mj;
  bit [1:0] m_h;

  always @(posedge clk) begin
    T1 = int'(c_s1) + 1; T2 = int'(c_s2) + 1; SJ = int'(c_sj) + 1;
    if (rst) begin
      m_cnt = 0; m_rxs = 1; m_prev = 1; m_h = 2'b11;
      seg = 0; k = 0; len1 = T1; len2 = T2; done = 0;
      e_pulse = 0; e_bit = 1;
    end else begin
      L = m_rxs;
      tk = (m_cnt == int'(c_pre));
      m_cnt = tk ? 0 : m_cnt + 1;
      e_pulse = 0;
      if (tk) begin
        ed = m_prev & ~L;
        mj = (m_h[1] & m_h[0]) | (m_h[1] & L) | (m_h[0] & L);
        rs = 0;
        if (ed && idle) rs = 1;
        else if (ed && !done && !txd && seg != 0) begin
          done = 1;
          if (seg == 1) len1 = T1 + ((k < SJ) ? k : SJ);
          else if (len2 - k + 1 <= SJ) rs = 1;
          else len2 = len2 - SJ;
        end
        if (rs) begin
          seg = 1; k = 1; len1 = T1; len2 = T2; done = 1;
        end else begin
          if (seg == 1 && k == len1) begin
            e_pulse = 1;
            e_bit = c_tr ? mj : L;
          end
          case (seg)
            0: begin seg = 1; k = 1; end
            1: if (k >= len1) begin seg = 2; k = 1; end else k++;
            default: if (k >= len2) begin
                seg = 0; k = 0; len1 = T1; len2 = T2; done = 0;
              end else k++;
          endcase
        end
        m_prev = L;
        m_h = {m_h[0], L};
      end
      m_rxs = rx;
    end
  end

  always @(negedge clk) begin
    if (!rst && (e_pulse || pulse)) begin
      check(tag, int'(pulse), int'(e_pulse), "strobe vs model");
      if (e_pulse) check(tag, int'(sbit), int'(e_bit), "sampled bit vs model");
    end
  end

  task automatic apply_cfg(int p, int s1, int s2, int sj, bit tr);
    @(negedge clk);
    rst = 1; rx = 1; idle = 1; txd = 0;
    c_pre = 8'(p); c_s1 = 4'(s1); c_s2 = 3'(s2); c_sj = 2'(sj); c_tr = tr;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic wait_pulse(output int at);
    do @(negedge clk); while (!pulse);
    at = cyc;
  endtask

  // dir: 1 late, -1 early, 0 random length 1..base
  task automatic wave(int cnt, int base, int jit, int dir);
    for (int i = 0; i < cnt; i++) begin
      int len;
      if (dir > 0)      len = base + int'($urandom % (jit + 1));
      else if (dir < 0) len = base - int'($urandom % (jit + 1));
      else              len = 1 + int'($urandom % base);
      if (len < 1) len = 1;
      @(negedge clk) rx = ~rx;
      repeat (len - 1) @(negedge clk);
    end
    @(negedge clk) rx = 1;
  endtask

  initial begin
    int t_a, t_b, n0, q, bitc;
    void'($urandom(32'h1234_5678));

    // R1 reset state
    apply_cfg(1, 5, 2, 1, 0);
    @(negedge clk);
    check("R1", int'(pulse), 0, "strobe after reset");
    check("R1", int'(sbit), 1, "bit after reset");

    // R2 free-running bit length on a quiet line
    tag = "R2";
    idle = 0;
    wait_pulse(t_a);
    wait_pulse(t_b);
    check("R2", t_b - t_a, (1 + 6 + 3) * 2, "strobe spacing");
    apply_cfg(3, 2, 4, 0, 0);
    idle = 0;
    wait_pulse(t_a);
    wait_pulse(t_b);
    check("R2", t_b - t_a, (1 + 3 + 5) * 4, "strobe spacing p=3");

    // R4 hard sync delay; R3 strobe at end of first segment
    tag = "R4";
    apply_cfg(2, 6, 2, 1, 0);
    repeat (5) @(negedge clk);
    rx = 0; n0 = cyc;
    wait_pulse(t_a);
    q = 3;
    check("R4", int'((t_a - n0) >= 7 * q + 2), 1, "hard sync delay lower bound");
    check("R3", int'((t_a - n0) <= 7 * q + q + 1), 1, "hard sync delay upper bound");
    check("R9", int'(sbit), 0, "dominant sampled after hard sync");
    idle = 0;
    repeat (40) @(negedge clk);
    rx = 1;
    repeat (60) @(negedge clk);

    // R5 late edges
    tag = "R5";
    apply_cfg(1, 7, 3, 1, 0);
    bitc = 13 * 2;
    wave(2, 6, 0, 1);
    idle = 0;
    wave(30, bitc, 8, 1);

    // R6 early edges
    tag = "R6";
    apply_cfg(1, 7, 3, 1, 0);
    wave(2, 6, 0, 1);
    idle = 0;
    wave(30, bitc - 10, 8, 1);

    // R7 glitch trains
    tag = "R7";
    apply_cfg(0, 5, 4, 3, 0);
    wave(2, 4, 0, 1);
    idle = 0;
    wave(120, 6, 0, 0);

    // R8 own dominant suppresses adjustment
    tag = "R8";
    apply_cfg(1, 7, 3, 3, 0);
    wave(2, 6, 0, 1);
    idle = 0; txd = 1;
    wave(20, bitc - 6, 10, 1);
    wave(20, bitc + 2, 10, 1);
    txd = 0;

    // R9 single sample, R10 majority vote
    tag = "R9";
    apply_cfg(1, 4, 2, 1, 0);
    wave(2, 6, 0, 1);
    idle = 0;
    wave(80, 12, 0, 0);
    tag = "R10";
    apply_cfg(0, 6, 3, 2, 1);
    wave(2, 6, 0, 1);
    idle = 0;
    wave(150, 5, 0, 0);
    apply_cfg(2, 9, 5, 1, 1);
    idle = 0;
    wave(80, 10, 0, 0);

    // mixed random settings
    tag = "R5 R6 R7 R10 random";
    for (int r = 0; r < 20; r++) begin
      apply_cfg(int'($urandom % 4), int'($urandom % 16), int'($urandom % 8),
                int'($urandom % 4), bit'($urandom % 2));
      wave(2, 8, 0, 0);
      idle = 0;
      txd = bit'($urandom % 4 == 0);
      wave(20, 60, 0, 0);
      idle = 1; txd = 0;
      wave(1, 3, 0, 1);
      idle = 0;
      wave(20, 60, 0, 0);
    end

    repeat (20) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(190000 * 4);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R2 watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule